// File: doc/BRIEF.md
# Serial SAR Conversion Sequencer

This block is the digital control side of a 10-bit successive-approximation converter that sits behind a synchronous serial port. The serial pins are a chip select (active low), a serial clock that idles low, a data input and a data output. In each transfer the host clocks in a 4-bit channel address, MSB first. At the same time it clocks out the result of the previous conversion, also MSB first. The block opens a sample window for the analog front end while the transfer runs. When the window closes, the block runs the conversion from its own clock: it presents a trial code to the capacitor DAC and reads a single comparator bit on each step.

The serial pins are oversampled on the block clock `clk` through a two-stage synchronizer. Each serial-clock edge therefore takes effect on the third rising `clk` edge after the pin changes. The conversion steps once every `CONV_DIV` clock cycles. A transfer may be 10 clocks long, 16 clocks long, or any length from 10 to 16 when chip select goes high between transfers. A long transfer depends on a serial-clock rising edge arriving while the conversion is still running. If none arrives, the extra clocks are read as the start of a new transfer, and only a chip-select toggle brings the port back into step. Channel codes 0 to 4 select analog inputs. Three codes give fixed self-test results, and the remaining codes give zero.

Top module: `sar_serial_seq`

## Requirements
- R1: The address is the level of `sdi` on the first four `sclk` rising edges of a transfer, MSB first. `mux_sel` takes the new address after the fourth rising edge and is otherwise unchanged.
- R2: While `cs_n` is low, `sdo` shows bit 9 of the last completed result before the first falling edge. After falling edge k (1 to 9) it shows bit 9-k. From the tenth falling edge on it is 0. The result is 0 after reset.
- R3: `sdo_oe` is high exactly while `cs_n` is low. The pad is high-impedance otherwise.
- R4: `samp_en` rises on the fourth `sclk` falling edge of a transfer and falls on the tenth. A high level on `cs_n` also clears it.
- R5: `eoc` is high out of reset, goes low on the tenth falling edge, and rises when the new result is stored.
- R6: The conversion takes 10 steps of `CONV_DIV` clock cycles each, deciding bits 9 down to 0. On each step the trial bit is kept when `cmp_in` is 1 and cleared when it is 0. `eoc` rises 10*`CONV_DIV` clock edges after the edge that registers the tenth falling edge. `dac_code` holds 0x200 at the first step.
- R7: Addresses 0x0 to 0x4 convert the selected input: the stored result is the code that the comparator decisions produce.
- R8: Addresses 0xB, 0xC and 0xD give 0x200, 0x000 and 0x3FF, whatever `cmp_in` does.
- R9: Addresses 0x5 to 0xA, 0xE and 0xF give 0x000.
- R10: With `cs_n` held low and 10 clocks per transfer, the next transfer starts with the first rising edge after the conversion completes.
- R11: With `cs_n` held low, a rising edge during the conversion keeps the transfer open until the sixteenth falling edge. No new sample window opens before then.
- R12: With `cs_n` high between transfers, a transfer of any length from 10 to 16 clocks works.
- R13: If a transfer of more than 10 clocks has no rising edge before the conversion completes, the later clocks start a new transfer: they open a sample window and start no conversion. A `cs_n` high level restores step.
- R14: After reset, `eoc`=1, `samp_en`=0, `sdo_oe`=0, `dac_code`=0 and `mux_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the conversion time base |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial address in |
| sdo | output | 1 | Serial result out |
| sdo_oe | output | 1 | Output enable for the `sdo` pad |
| samp_en | output | 1 | Sample window for the analog front end |
| mux_sel | output | 4 | Channel or self-test code for the front end |
| dac_code | output | 10 | Trial code for the capacitor DAC |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| eoc | output | 1 | End of conversion, high when a result is ready |

## Verification
Each serial edge acts three `clk` edges after the pin moves. The bench therefore waits six clock cycles after every `sclk` edge before it samples `sdo`, `samp_en`, `mux_sel` or `eoc`. This puts every sample after the edge's effect and before the next serial edge. The `eoc` rise is due exactly 3 + 10*`CONV_DIV` cycles after the cycle in which the tenth falling edge is driven. The bench counts clock edges from that cycle and compares the total. Conversion results appear one transfer later, so a scoreboard pairs each word that is read with the expected value queued by the transfer before it.

// File: rtl/sar_serial_seq.sv
module sar_serial_seq #(
  parameter int RES_W     = 10,
  parameter int LONG_CLKS = 16,
  parameter int CONV_DIV  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             samp_en,
  output logic [3:0]       mux_sel,
  output logic [RES_W-1:0] dac_code,
  input  logic             cmp_in,
  output logic             eoc
);
  localparam int ADDR_W = 4;
  localparam int CNT_W  = $clog2(LONG_CLKS + 1);
  localparam int SW     = $clog2(RES_W);
  localparam int DW     = (CONV_DIV > 1) ? $clog2(CONV_DIV) : 1;
  localparam logic [CNT_W-1:0] C_ADDR   = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] C_ADDR_L = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] C_RES    = CNT_W'(RES_W);
  localparam logic [CNT_W-1:0] C_RES_L  = CNT_W'(RES_W - 1);
  localparam logic [CNT_W-1:0] C_LONG   = CNT_W'(LONG_CLKS);
  localparam logic [CNT_W-1:0] C_LONG_L = CNT_W'(LONG_CLKS - 1);
  localparam logic [DW-1:0]    D_LAST   = DW'(CONV_DIV - 1);
  localparam logic [SW-1:0]    S_TOP    = SW'(RES_W - 1);
  localparam logic [RES_W-1:0] CODE_MID = {1'b1, {(RES_W-1){1'b0}}};

  logic [2:0]        sclk_p;
  logic [1:0]        sdi_p, cs_p;
  logic              rise, fall, cs_idle, sdi_s;
  logic [CNT_W-1:0]  rcnt, fcnt;
  logic              long_q;
  logic [ADDR_W-2:0] addr_sh;
  logic [ADDR_W-1:0] conv_addr;
  logic              busy, start, tick, conv_done, forced, dec;
  logic [SW-1:0]     step;
  logic [DW-1:0]     div;
  logic [RES_W-1:0]  sar, nxt, res_q, fix_code, out_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_p <= '0;
      sdi_p  <= '0;
      cs_p   <= '1;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      sdi_p  <= {sdi_p[0], sdi};
      cs_p   <= {cs_p[0], cs_n};
    end

  assign rise    = sclk_p[1] & ~sclk_p[2];
  assign fall    = ~sclk_p[1] & sclk_p[2];
  assign cs_idle = cs_p[1];
  assign sdi_s   = sdi_p[1];

  assign start     = !cs_idle && fall && (fcnt == C_RES_L);
  assign tick      = busy && (div == D_LAST);
  assign conv_done = tick && (step == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rcnt    <= '0;
      fcnt    <= '0;
      long_q  <= 1'b0;
      samp_en <= 1'b0;
      addr_sh <= '0;
      mux_sel <= '0;
    end else if (cs_idle) begin
      rcnt    <= '0;
      fcnt    <= '0;
      long_q  <= 1'b0;
      samp_en <= 1'b0;
    end else if (rise) begin
      if (rcnt != C_LONG) rcnt <= rcnt + 1'b1;
      if (rcnt < C_ADDR_L) addr_sh <= {addr_sh[ADDR_W-3:0], sdi_s};
      if (rcnt == C_ADDR_L) mux_sel <= {addr_sh, sdi_s};
      if (fcnt == C_RES && busy) long_q <= 1'b1;
    end else if (fall) begin
      if (fcnt == C_LONG_L) begin
        rcnt   <= '0;
        fcnt   <= '0;
        long_q <= 1'b0;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
      if (fcnt == C_ADDR_L) samp_en <= 1'b1;
      if (fcnt == C_RES_L) samp_en <= 1'b0;
    end else if (conv_done && fcnt == C_RES && !long_q) begin
      rcnt <= '0;
      fcnt <= '0;
    end

  always_comb begin
    forced   = 1'b1;
    fix_code = '0;
    case (conv_addr)
      4'h0, 4'h1, 4'h2, 4'h3, 4'h4: forced = 1'b0;
      4'hB: fix_code = CODE_MID;
      4'hD: fix_code = '1;
      default: ;
    endcase
  end

  assign dec = forced ? fix_code[step] : cmp_in;

  always_comb begin
    nxt       = sar;
    nxt[step] = dec;
    if (step != '0) nxt[step - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy      <= 1'b0;
      step      <= '0;
      div       <= '0;
      sar       <= '0;
      res_q     <= '0;
      conv_addr <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      step      <= S_TOP;
      div       <= '0;
      sar       <= CODE_MID;
      conv_addr <= mux_sel;
    end else if (busy) begin
      if (tick) begin
        div  <= '0;
        sar  <= nxt;
        step <= step - 1'b1;
        if (step == '0) begin
          busy  <= 1'b0;
          res_q <= nxt;
        end
      end else begin
        div <= div + 1'b1;
      end
    end

  assign out_sh   = res_q << fcnt;
  assign sdo      = (fcnt < C_RES) ? out_sh[RES_W-1] : 1'b0;
  assign sdo_oe   = ~cs_idle;
  assign dac_code = sar;
  assign eoc      = ~busy;

  // R4: conversion starts only as the sample window closes
  p_hold_after_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc) |-> ($past(samp_en) && !samp_en));

  // R4: the window opens with four falling edges counted
  p_sample_on_fourth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(samp_en) |-> (fcnt == C_ADDR));

  // R1: the address stays put while the front end samples
  p_addr_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_en && $past(samp_en)) |-> $stable(mux_sel));

  // R2: the stored result changes only when a conversion completes
  p_result_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(eoc) |-> $stable(res_q));

  // R6: the first trial code is half scale
  p_first_trial_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc) |-> (dac_code == CODE_MID));
endmodule

// File: tb/sar_serial_seq_test.sv
module sar_serial_seq_test;
  localparam int CD = 4;
  localparam int H  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdo_oe, samp_en, eoc, cmp_in;
  logic [3:0] mux_sel;
  logic [9:0] dac_code;
  logic [9:0] chan [5];

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [9:0] exp_q[$];
  logic [9:0] got_q[$];
  string tag_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign cmp_in = (mux_sel < 4'd5) ? (chan[mux_sel[2:0]] >= dac_code) : 1'b1;

  sar_serial_seq #(.RES_W(10), .LONG_CLKS(16), .CONV_DIV(CD)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .samp_en(samp_en), .mux_sel(mux_sel),
    .dac_code(dac_code), .cmp_in(cmp_in), .eoc(eoc)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [9:0] model(input logic [3:0] a);
    case (a)
      4'h0, 4'h1, 4'h2, 4'h3, 4'h4: return chan[a[2:0]];
      4'hB: return 10'h200;
      4'hD: return 10'h3FF;
      default: return 10'h000;
    endcase
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic xfer(input logic [3:0] a, input int n, input bit stay_low,
                      input bit stall, input string tag);
    logic [9:0] got;
    int t10;
    got = '0;
    t10 = 0;
    while (!eoc) @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    chk(sdo_oe == 1'b1, "R3", "oe while selected", sdo_oe, 1);
    got[9] = sdo;
    for (int i = 1; i <= n; i++) begin
      sdi = (i <= 4) ? a[4-i] : 1'b0;
      if (stall && i == 11) begin
        while (!eoc) @(negedge clk);
        repeat (H) @(negedge clk);
      end
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
      if (i == 10) t10 = cyc;
      repeat (H) @(negedge clk);
      if (i <= 9) got[9-i] = sdo;
      if (i == 4) chk(mux_sel == a, "R1", "address after 4th rise", mux_sel, a);
      if (i <= 10)
        chk(samp_en == (i >= 4 && i <= 9), "R4", $sformatf("window at fall %0d", i),
            samp_en, (i >= 4 && i <= 9));
      if (i > 10 && !stall)
        chk(samp_en == 1'b0, "R11", $sformatf("no window at fall %0d", i), samp_en, 0);
      if (i == 10) begin
        chk(eoc == 1'b0, "R5", "eoc low after 10th fall", eoc, 0);
        chk(sdo == 1'b0, "R2", "sdo zero after 10th fall", sdo, 0);
        if (n == 10) begin
          while (!eoc) @(negedge clk);
          chk(cyc - t10 == 3 + 10*CD, "R6", "conversion time", cyc - t10, 3 + 10*CD);
        end
      end
    end
    sdi = 1'b0;
    got_q.push_back(got);
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
    if (stall) begin
      chk(samp_en == 1'b1, "R13", "stray window after lost step", samp_en, 1);
      chk(eoc == 1'b1, "R13", "no stray conversion", eoc, 1);
    end
    if (!stay_low) begin
      cs_n = 1'b1;
      repeat (H) @(negedge clk);
      chk(sdo_oe == 1'b0, "R3", "oe off when deselected", sdo_oe, 0);
      if (stall) chk(samp_en == 1'b0, "R13", "select toggle clears window", samp_en, 0);
    end
  endtask

  initial begin : monitor
    logic [9:0] g, e;
    string t;
    forever begin
      @(negedge clk);
      if (got_q.size() > 0 && exp_q.size() > 0) begin
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(g == e, t, "serial result (R2)", g, e);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : driver
    chan[0] = 10'h2A5; chan[1] = 10'h001; chan[2] = 10'h3FE;
    chan[3] = 10'h155; chan[4] = 10'h3FF;
    exp_q.push_back(10'h000);
    tag_q.push_back("R14");
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(eoc == 1'b1, "R14", "eoc after reset", eoc, 1);
    chk(samp_en == 1'b0, "R14", "window after reset", samp_en, 0);
    chk(sdo_oe == 1'b0, "R14", "oe after reset", sdo_oe, 0);
    chk(dac_code == 10'h0, "R14", "dac after reset", dac_code, 0);
    chk(mux_sel == 4'h0, "R14", "address after reset", mux_sel, 0);

    xfer(4'h0, 10, 1'b0, 1'b0, "R7");
    xfer(4'hB, 16, 1'b0, 1'b0, "R8");
    xfer(4'h1, 13, 1'b0, 1'b0, "R12");
    xfer(4'hC, 10, 1'b0, 1'b0, "R8");
    xfer(4'hD, 12, 1'b0, 1'b0, "R8");
    xfer(4'h7, 10, 1'b0, 1'b0, "R9");
    xfer(4'hF, 11, 1'b0, 1'b0, "R9");
    xfer(4'h2, 10, 1'b0, 1'b0, "R7");
    xfer(4'h3, 10, 1'b1, 1'b0, "R10");
    xfer(4'h4, 10, 1'b1, 1'b0, "R10");
    xfer(4'h0, 16, 1'b1, 1'b0, "R11");
    xfer(4'hE, 16, 1'b1, 1'b0, "R11");
    xfer(4'h2, 16, 1'b1, 1'b0, "R11");
    xfer(4'h1, 10, 1'b0, 1'b0, "R10");
    xfer(4'h3, 16, 1'b0, 1'b1, "R13");
    xfer(4'h4, 10, 1'b0, 1'b0, "R7");
    xfer(4'h0, 10, 1'b0, 1'b0, "R7");
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 1, "R2", "scoreboard drained", exp_q.size(), 1);
    finish_run();
  end
endmodule